// File: doc/BRIEF.md
# Backplane Command Slave with Sequencing Control

This block sits between an asynchronous 24-bit backplane bus and a two-layer neural processing engine. It responds only when the upper sixteen address bits match a fixed base window. Inside that window, the low address byte is a command code, so the module offers 256 codes. Each accepted access raises a one-cycle command pulse carrying its code, which neighbouring logic can use. Two codes also map to storage inside the block: a 16-bit control word and an 8-bit status word.

The control word drives three signals that sequence the first neural layer. Bit 0 freezes the layers, bit 1 holds them in master reset, and bit 2 is the layer-1 start strobe. The status word is resampled every clock. It shows four flag inputs from each layer: the layer-1 flags sit in bits 3:0 (bit 0 is the layer-1 busy flag) and the layer-2 flags sit in bits 7:4.

Transfers are 8 or 16 bits wide, selected by two active-low data strobes. The address strobe, both data strobes and the interrupt-acknowledge input pass through a synchronizer before the handshake state machine sees them. The block acknowledges with an active-low data acknowledge. That acknowledge stays low until the master removes its data strobes.

Top module: `bus_cmd_slave`

## Requirements
- R1: While reset is held and on leaving it, the data acknowledge is high (inactive), the read-data enable is low, and freeze, master reset and start are all low.
- R2: An access whose address bits 23:8 differ from the base (0xFE20) gets no acknowledge, no command pulse and no register change.
- R3: A write to code 0x00 stores the control word. Outputs follow its bits: freeze = bit 0, master reset = bit 1, start = bit 2. A 16-bit read of code 0x00 returns the whole stored word.
- R4: Data strobe 0 (active low) selects bits 7:0 and data strobe 1 selects bits 15:8. A write changes only the selected bytes. On a read, unselected bytes return zero.
- R5: A read of code 0x01 returns {8'h00, layer-2 flags, layer-1 flags}, reflecting flag inputs that have been stable for at least two clocks.
- R6: A read of any code other than 0x00 and 0x01 returns zero and is still acknowledged. A write to such a code is acknowledged and changes no register.
- R7: Acknowledge falls only after the synchronized address strobe and at least one synchronized data strobe are seen active. While the address strobe alone is active there is no acknowledge. Acknowledge rises again within a few clocks of the data strobes being released.
- R8: Every acknowledged in-window access produces exactly one single-cycle command pulse, with the command code equal to address bits 7:0.
- R9: An access made with interrupt acknowledge active is acknowledged with the vector 0x40 in bits 7:0 and zero above it. It produces no command pulse and no register write.
- R10: The read-data enable is high only while acknowledging a read or interrupt acknowledge, and never during a write acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Bus address, stable while strobes are active |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_ds_n | input | 2 | Data strobes, active low; bit 0 low byte, bit 1 high byte |
| bus_write | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_iack_n | input | 1 | Interrupt acknowledge, active low |
| bus_wdata | input | 16 | Write data from the master |
| bus_rdata | output | 16 | Read data toward the master |
| bus_rdata_en | output | 1 | High while read data should be driven onto the bus |
| bus_dtack_n | output | 1 | Data acknowledge, active low |
| l1_flags | input | 4 | Layer-1 flags (bit 0 busy) |
| l2_flags | input | 4 | Layer-2 flags |
| cmd_fire | output | 1 | One-cycle pulse per accepted in-window access |
| cmd_code | output | 8 | Code of the last accepted access |
| freeze | output | 1 | Freeze request to both layers |
| mreset | output | 1 | Master reset to both layers |
| start1 | output | 1 | Layer-1 start strobe |

## Verification
The assertions take for granted that the master follows the bus protocol. Address, write flag and write data must be stable from the moment a strobe goes active until the acknowledge appears, and strobes are released only after the acknowledge or after a timeout. The bench drives all bus inputs together on the falling clock edge, and it changes address and data only while every strobe is inactive. It always removes both strobes before it starts the next access, so each handshake starts from the idle state.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int ADDR_W = 24;
  localparam int CODE_W = 8;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;
  localparam int FLAG_W = 4;
  localparam int STAT_W = 2 * FLAG_W;

  localparam int CTRL_FREEZE_BIT = 0;
  localparam int CTRL_MRESET_BIT = 1;
  localparam int CTRL_START_BIT  = 2;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_ACK  = 2'd1,
    HS_SKIP = 2'd2
  } hs_state_t;

  typedef struct packed {
    logic [FLAG_W-1:0] l2;
    logic [FLAG_W-1:0] l1;
  } status_t;

  function automatic logic addr_in_window(input logic [ADDR_W-1:0] a,
                                          input logic [ADDR_W-1:0] base);
    return a[ADDR_W-1:CODE_W] == base[ADDR_W-1:CODE_W];
  endfunction

  function automatic logic [DATA_W-1:0] lane_expand(input logic [LANES-1:0] l);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{l[i]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0] l);
    logic [DATA_W-1:0] m;
    m = lane_expand(l);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;
  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[CHAIN_W-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/bcs_handshake.sv
module bcs_handshake
  import bcs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'hFE2000,
  parameter logic [7:0]        IACK_VECTOR = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_act,
  input  logic [LANES-1:0]  ds_act,
  input  logic              iack_act,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [DATA_W-1:0] rd_word,
  output logic              dtack_n,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en,
  output logic              cmd_fire,
  output logic [CODE_W-1:0] cmd_code,
  output logic              reg_we,
  output logic              strobes_on,
  output logic              acc_start,
  output logic              addr_hit,
  output logic              ds_any
);
  localparam logic [DATA_W-1:0] VEC_WORD = {{(DATA_W-8){1'b0}}, IACK_VECTOR};

  hs_state_t state_q;

  assign ds_any     = |ds_act;
  assign strobes_on = as_act && ds_any;
  assign acc_start  = (state_q == HS_IDLE) && strobes_on;
  assign addr_hit   = addr_in_window(addr, BASE_ADDR);
  assign reg_we     = acc_start && addr_hit && !iack_act && write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= HS_IDLE;
      dtack_n  <= 1'b1;
      rdata    <= '0;
      rdata_en <= 1'b0;
      cmd_fire <= 1'b0;
      cmd_code <= '0;
    end else begin
      cmd_fire <= 1'b0;
      case (state_q)
        HS_IDLE: begin
          if (acc_start) begin
            if (iack_act) begin
              state_q  <= HS_ACK;
              dtack_n  <= 1'b0;
              rdata    <= VEC_WORD;
              rdata_en <= 1'b1;
            end else if (addr_hit) begin
              state_q  <= HS_ACK;
              dtack_n  <= 1'b0;
              cmd_fire <= 1'b1;
              cmd_code <= addr[CODE_W-1:0];
              rdata    <= write ? '0 : (rd_word & lane_expand(ds_act));
              rdata_en <= !write;
            end else begin
              state_q <= HS_SKIP;
            end
          end
        end
        HS_ACK: begin
          if (!ds_any) begin
            state_q  <= HS_IDLE;
            dtack_n  <= 1'b1;
            rdata    <= '0;
            rdata_en <= 1'b0;
          end
        end
        HS_SKIP: begin
          if (!ds_any) state_q <= HS_IDLE;
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcs_regs.sv
module bcs_regs
  import bcs_pkg::*;
#(
  parameter logic [CODE_W-1:0] CTRL_CODE = 8'h00,
  parameter logic [CODE_W-1:0] STAT_CODE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [LANES-1:0]  lanes,
  input  logic [DATA_W-1:0] wdata,
  input  logic              reg_we,
  input  logic [FLAG_W-1:0] l1_flags,
  input  logic [FLAG_W-1:0] l2_flags,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              ctrl_we
);
  status_t status_q;

  assign ctrl_we = reg_we && (code == CTRL_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
    end else begin
      status_q <= '{l2: l2_flags, l1: l1_flags};
      if (ctrl_we) ctrl_q <= lane_merge(ctrl_q, wdata, lanes);
    end
  end

  always_comb begin
    rd_word = '0;
    if (code == CTRL_CODE)      rd_word = ctrl_q;
    else if (code == STAT_CODE) rd_word = {{(DATA_W-STAT_W){1'b0}}, status_q};
  end
endmodule

// File: rtl/bus_cmd_slave.sv
module bus_cmd_slave
  import bcs_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 24'hFE2000,
  parameter logic [7:0]        IACK_VECTOR = 8'h40,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_as_n,
  input  logic [LANES-1:0]  bus_ds_n,
  input  logic              bus_write,
  input  logic              bus_iack_n,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_en,
  output logic              bus_dtack_n,
  input  logic [FLAG_W-1:0] l1_flags,
  input  logic [FLAG_W-1:0] l2_flags,
  output logic              cmd_fire,
  output logic [CODE_W-1:0] cmd_code,
  output logic              freeze,
  output logic              mreset,
  output logic              start1
);
  localparam int SYNC_W = LANES + 2;

  logic [SYNC_W-1:0] strobe_raw, strobe_s;
  logic              as_act, iack_act;
  logic [LANES-1:0]  ds_act;
  logic [DATA_W-1:0] rd_word, ctrl_q;
  logic              reg_we, ctrl_we;
  logic              strobes_on, acc_start, addr_hit, ds_any;

  assign strobe_raw = {bus_iack_n, bus_ds_n, bus_as_n};

  bcs_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_raw), .q(strobe_s)
  );

  assign as_act   = !strobe_s[0];
  assign ds_act   = ~strobe_s[LANES:1];
  assign iack_act = !strobe_s[SYNC_W-1];

  bcs_handshake #(.BASE_ADDR(BASE_ADDR), .IACK_VECTOR(IACK_VECTOR)) u_hs (
    .clk(clk), .rst_n(rst_n), .as_act(as_act), .ds_act(ds_act), .iack_act(iack_act),
    .addr(bus_addr), .write(bus_write), .rd_word(rd_word),
    .dtack_n(bus_dtack_n), .rdata(bus_rdata), .rdata_en(bus_rdata_en),
    .cmd_fire(cmd_fire), .cmd_code(cmd_code), .reg_we(reg_we),
    .strobes_on(strobes_on), .acc_start(acc_start), .addr_hit(addr_hit), .ds_any(ds_any)
  );

  bcs_regs u_regs (
    .clk(clk), .rst_n(rst_n), .code(bus_addr[CODE_W-1:0]), .lanes(ds_act),
    .wdata(bus_wdata), .reg_we(reg_we), .l1_flags(l1_flags), .l2_flags(l2_flags),
    .rd_word(rd_word), .ctrl_q(ctrl_q), .ctrl_we(ctrl_we)
  );

  assign freeze = ctrl_q[CTRL_FREEZE_BIT];
  assign mreset = ctrl_q[CTRL_MRESET_BIT];
  assign start1 = ctrl_q[CTRL_START_BIT];
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_dtack_n,
  input logic        bus_rdata_en,
  input logic        cmd_fire,
  input logic        strobes_on,
  input logic        acc_start,
  input logic        addr_hit,
  input logic        iack_act,
  input logic        ds_any,
  input logic        ctrl_we,
  input logic [15:0] ctrl_q
);
  assert_dtack_after_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_dtack_n) |-> $past(strobes_on));

  assert_dtack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_dtack_n && !ds_any) |=> bus_dtack_n);

  assert_miss_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !addr_hit && !iack_act) |=> (bus_dtack_n && !cmd_fire));

  assert_fire_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> !cmd_fire);

  assert_iack_nofire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && iack_act) |=> (!cmd_fire && !bus_dtack_n));

  assert_rden_in_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_en |-> !bus_dtack_n);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> $stable(ctrl_q));
endmodule

bind bus_cmd_slave bcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_dtack_n(bus_dtack_n), .bus_rdata_en(bus_rdata_en),
  .cmd_fire(cmd_fire), .strobes_on(strobes_on), .acc_start(acc_start),
  .addr_hit(addr_hit), .iack_act(iack_act), .ds_any(ds_any),
  .ctrl_we(ctrl_we), .ctrl_q(ctrl_q)
);

// File: tb/bus_cmd_slave_test.sv
module bus_cmd_slave_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_as_n = 1'b1;
  logic [1:0]  bus_ds_n = 2'b11;
  logic        bus_write = 1'b0;
  logic        bus_iack_n = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rdata_en, bus_dtack_n;
  logic [3:0]  l1_flags = '0, l2_flags = '0;
  logic        cmd_fire;
  logic [7:0]  cmd_code;
  logic        freeze, mreset, start1;

  int n_checks = 0, n_fail = 0, fire_cnt = 0;
  logic [7:0] last_code = '0;

  always #4 clk = ~clk;

  bus_cmd_slave uut (.*);

  always @(negedge clk) if (cmd_fire) begin
    fire_cnt++;
    last_code = cmd_code;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_access(input logic [23:0] a, input logic wr, input logic [1:0] lanes,
                            input logic [15:0] wd, input logic iack,
                            output logic [15:0] rd, output logic acked, output logic rden);
    acked = 1'b0; rd = '0; rden = 1'b0;
    @(negedge clk);
    bus_addr = a; bus_write = wr; bus_wdata = wd; bus_iack_n = !iack;
    bus_as_n = 1'b0; bus_ds_n = ~lanes;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (!bus_dtack_n) begin acked = 1'b1; break; end
    end
    if (acked) begin rd = bus_rdata; rden = bus_rdata_en; end
    @(negedge clk);
    bus_as_n = 1'b1; bus_ds_n = 2'b11; bus_iack_n = 1'b1;
    if (acked) begin
      logic released = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (bus_dtack_n) begin released = 1'b1; break; end
      end
      check("R7 release", released, 1'b1);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 dtack", bus_dtack_n, 1'b1);
    check("R1 rden", bus_rdata_en, 1'b0);
    check("R1 ctrl outs", {freeze, mreset, start1}, 3'b000);
  endtask

  task automatic t_ctrl;
    logic [15:0] rd; logic ak, re;
    int f0 = fire_cnt;
    bus_access(24'hFE2000, 1'b1, 2'b11, 16'hAB05, 1'b0, rd, ak, re);
    check("R3 write ack", ak, 1'b1);
    check("R10 no rden on write", re, 1'b0);
    check("R3 freeze/mreset/start", {freeze, mreset, start1}, 3'b101);
    check("R8 one pulse", fire_cnt - f0, 1);
    check("R8 code", last_code, 8'h00);
    bus_access(24'hFE2000, 1'b0, 2'b11, 16'h0000, 1'b0, rd, ak, re);
    check("R3 readback", rd, 16'hAB05);
    check("R10 rden on read", re, 1'b1);
  endtask

  task automatic t_lanes;
    logic [15:0] rd; logic ak, re;
    bus_access(24'hFE2000, 1'b1, 2'b10, 16'h7102, 1'b0, rd, ak, re);
    check("R4 high lane leaves outs", {freeze, mreset, start1}, 3'b101);
    bus_access(24'hFE2000, 1'b1, 2'b01, 16'hFF02, 1'b0, rd, ak, re);
    check("R4 low lane write", {freeze, mreset, start1}, 3'b010);
    bus_access(24'hFE2000, 1'b0, 2'b10, 16'h0000, 1'b0, rd, ak, re);
    check("R4 high lane read", rd, 16'h7100);
    bus_access(24'hFE2000, 1'b0, 2'b01, 16'h0000, 1'b0, rd, ak, re);
    check("R4 low lane read", rd, 16'h0002);
  endtask

  task automatic t_status;
    logic [15:0] rd; logic ak, re;
    int f0;
    l1_flags = 4'hA; l2_flags = 4'h5;
    repeat (3) @(negedge clk);
    f0 = fire_cnt;
    bus_access(24'hFE2001, 1'b0, 2'b11, 16'h0000, 1'b0, rd, ak, re);
    check("R5 status a", rd, 16'h005A);
    check("R8 status code", last_code, 8'h01);
    check("R8 status pulse", fire_cnt - f0, 1);
    l1_flags = 4'h6; l2_flags = 4'h3;
    repeat (3) @(negedge clk);
    bus_access(24'hFE2001, 1'b0, 2'b01, 16'h0000, 1'b0, rd, ak, re);
    check("R5 status b", rd, 16'h0036);
  endtask

  task automatic t_unmapped;
    logic [15:0] rd; logic ak, re;
    bus_access(24'hFE207F, 1'b0, 2'b11, 16'h0000, 1'b0, rd, ak, re);
    check("R6 unmapped ack", ak, 1'b1);
    check("R6 unmapped zero", rd, 16'h0000);
    check("R8 unmapped code", last_code, 8'h7F);
    bus_access(24'hFE20FF, 1'b1, 2'b11, 16'hFFFF, 1'b0, rd, ak, re);
    check("R6 unmapped write ack", ak, 1'b1);
    bus_access(24'hFE2000, 1'b0, 2'b11, 16'h0000, 1'b0, rd, ak, re);
    check("R6 ctrl untouched", rd, 16'h7102);
  endtask

  task automatic t_miss;
    logic [15:0] rd; logic ak, re;
    int f0 = fire_cnt;
    bus_access(24'hFE2100, 1'b1, 2'b11, 16'h0007, 1'b0, rd, ak, re);
    check("R2 no ack", ak, 1'b0);
    check("R2 no pulse", fire_cnt - f0, 0);
    check("R2 outs unchanged", {freeze, mreset, start1}, 3'b010);
    bus_access(24'h7E2000, 1'b0, 2'b11, 16'h0000, 1'b0, rd, ak, re);
    check("R2 upper bit miss", ak, 1'b0);
  endtask

  task automatic t_iack;
    logic [15:0] rd; logic ak, re;
    int f0 = fire_cnt;
    bus_access(24'hFE2000, 1'b1, 2'b01, 16'h0004, 1'b1, rd, ak, re);
    check("R9 iack ack", ak, 1'b1);
    check("R9 vector", rd, 16'h0040);
    check("R9 no pulse", fire_cnt - f0, 0);
    check("R9 no write", {freeze, mreset, start1}, 3'b010);
    check("R10 rden on iack", re, 1'b1);
  endtask

  task automatic t_as_only;
    int seen = 0;
    @(negedge clk);
    bus_addr = 24'hFE2000; bus_write = 1'b0; bus_as_n = 1'b0; bus_ds_n = 2'b11;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!bus_dtack_n) seen++;
    end
    check("R7 no ack on address strobe only", seen, 0);
    bus_as_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_lanes();
    t_status();
    t_unmapped();
    t_miss();
    t_iack();
    t_as_only();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule